// File: doc/BRIEF.md
# 12-bit Accumulator Processor Core

This block is a multi-cycle processor with a 12-bit data path and a single accumulator, built on the classic minicomputer model. Its visible state is a program counter, a 12-bit accumulator (AC), a one-bit link that catches carries and rotates, and a multiplier-quotient register (MQ). It talks to a synchronous single-port memory of 4096 twelve-bit words. That memory returns read data one clock after the address, and it performs a write at the clock edge when the write enable is high.

The core has no stack. A subroutine call leaves its return address in the first word of the called routine, and the routine returns with an indirect jump through that word. A conditional can only step over the instruction that follows it, so a branch is written as a skip followed by a jump. The core has one maskable interrupt. When it is taken, the core writes the PC to word 0 and continues at word 1. Interrupt-enable and interrupt-disable instructions turn it on and off. A halt instruction stops the core until reset.

Top module: `acc12_core`

## Requirements
- R1: While reset is high and after it is released, PC equals START_PC (default 0200 octal), AC and link are 0, halted_o is low, and mem_we stays low until an instruction stores.
- R2: An instruction is decoded as follows. Bits 11:9 hold the opcode: 0 AND, 1 TAD, 2 ISZ, 3 DCA, 4 JMS, 5 JMP, 6 IOT, 7 OPR. Bits 6:0 hold the word offset. When bit 7 is 1, the upper five address bits come from the instruction's own address; otherwise they are 0. When bit 8 is 1, the word at that address is the pointer to the real operand address.
- R3: AND replaces AC with AC bitwise-and the operand. TAD adds the operand to AC modulo 4096 and complements the link when the sum carries out.
- R4: ISZ writes the operand plus one back to memory, leaves AC unchanged, and steps PC past the next word when the written value is 0.
- R5: DCA stores AC at the operand address and then clears AC.
- R6: JMS writes the return address (the address after the JMS) into the target word and continues at the target plus one. JMP loads PC with the target. An indirect JMP through the saved word returns to the caller.
- R7: For an OPR with bit 8 equal to 0, the microoperations apply in this order. First bit 7 clears AC and bit 6 clears the link. Then bit 5 complements AC and bit 4 complements the link. Then bit 0 adds one to AC, and a carry out complements the link. Last, the 13-bit link:AC is rotated: bit 3 rotates right, otherwise bit 2 rotates left, and bit 1 doubles the rotate.
- R8: For an OPR with bit 8 equal to 1 and bit 0 equal to 0, the condition is true when any selected test holds: bit 6 tests AC bit 11 = 1, bit 5 tests AC = 0, bit 4 tests link = 1. Bit 3 inverts the result, so with no test selected the skip is unconditional. A skip adds one more to PC. Bit 7 clears AC after the test.
- R9: Bit 1 of that second OPR form halts the core. halted_o then stays high, PC stays frozen and no memory write occurs until reset.
- R10: For an OPR with bit 8 equal to 1 and bit 0 equal to 1, bit 7 clears AC first. Then bit 6 ORs MQ into AC, and bit 4 loads MQ from AC and clears AC. With bits 6 and 4 both set, AC and MQ exchange.
- R11: When the enable is on and irq is high at an instruction boundary, the core writes PC to address 0, continues at address 1 and clears the enable.
- R12: IOT 6001 (octal) turns the enable on, but only after the instruction that follows has completed. IOT 6002 turns it off. Every other IOT code has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Level-sensitive interrupt request |
| mem_rdata | input | 12 | Read data, valid one cycle after the address |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_we | output | 1 | Write enable for the current address |
| halted_o | output | 1 | Core has executed a halt |
| pc_o | output | 12 | Program counter |
| ac_o | output | 12 | Accumulator |
| link_o | output | 1 | Link bit |

## Verification
The bench builds the core with the default START_PC of 0200 octal and a save address of 0. Programs therefore sit in page 1, while data and the interrupt vector sit in page 0. With this layout, a current-page reference and a page-zero reference with the same 7-bit offset reach different words, so a wrong page select shows up as a wrong stored value. It also keeps the interrupt save word apart from every test program, so the word the interrupt stores can be read back without disturbing the code.

// File: rtl/acc12_pkg.sv
`timescale 1ns/1ps
package acc12_pkg;
  localparam int WORD_W = 12;
  localparam int OFFS_W = 7;
  localparam int OP_W   = 3;
  localparam int PAGE_W = WORD_W - OFFS_W;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'd0, OP_TAD = 3'd1, OP_ISZ = 3'd2, OP_DCA = 3'd3,
    OP_JMS = 3'd4, OP_JMP = 3'd5, OP_IOT = 3'd6, OP_OPR = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_INDIR, ST_MEMOP, ST_RDOP, ST_HALT
  } state_e;

  // add with carry into the link: returns {new_link, sum}
  function automatic logic [WORD_W:0] add_link(input logic lnk,
                                               input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b);
    logic [WORD_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return {lnk ^ s[WORD_W], s[WORD_W-1:0]};
  endfunction

  // effective address from page select bit and offset
  function automatic logic [WORD_W-1:0] eff_addr(input logic [WORD_W-1:0] here,
                                                 input logic cur_page,
                                                 input logic [OFFS_W-1:0] offs);
    logic [PAGE_W-1:0] pg;
    pg = cur_page ? here[WORD_W-1:OFFS_W] : '0;
    return {pg, offs};
  endfunction

  // 13-bit rotate of link:AC, right when dir_r else left
  function automatic logic [WORD_W:0] rot13(input logic [WORD_W:0] la,
                                            input logic dir_r);
    return dir_r ? {la[0], la[WORD_W:1]} : {la[WORD_W-1:0], la[WORD_W]};
  endfunction
endpackage

// File: rtl/acc12_opr1.sv
`timescale 1ns/1ps
module acc12_opr1 import acc12_pkg::*; (
  input  logic [WORD_W-1:0] ac_i,
  input  logic              link_i,
  input  logic [7:0]        ctl_i,
  output logic [WORD_W-1:0] ac_o,
  output logic              link_o
);
  logic [WORD_W:0] la;
  logic            do_rot;

  always_comb begin
    la = {link_i, ac_i};
    if (ctl_i[7]) la[WORD_W-1:0] = '0;
    if (ctl_i[6]) la[WORD_W] = 1'b0;
    if (ctl_i[5]) la[WORD_W-1:0] = ~la[WORD_W-1:0];
    if (ctl_i[4]) la[WORD_W] = ~la[WORD_W];
    if (ctl_i[0]) la = add_link(la[WORD_W], la[WORD_W-1:0], {{(WORD_W-1){1'b0}}, 1'b1});
    do_rot = ctl_i[3] | ctl_i[2];
    if (do_rot) begin
      la = rot13(la, ctl_i[3]);
      if (ctl_i[1]) la = rot13(la, ctl_i[3]);
    end
    ac_o   = la[WORD_W-1:0];
    link_o = la[WORD_W];
  end

  // R7: lone increment and lone complement behave arithmetically
  always_comb begin
    if (ctl_i == 8'b0000_0001)
      p_iac_r7: assert (ac_o == ac_i + 12'd1);
    if (ctl_i == 8'b0010_0000)
      p_cma_r7: assert ((ac_o ^ ac_i) == '1 && link_o == link_i);
  end
endmodule

// File: rtl/acc12_skip.sv
`timescale 1ns/1ps
module acc12_skip import acc12_pkg::*; (
  input  logic [WORD_W-1:0] ac_i,
  input  logic              link_i,
  input  logic              t_neg_i,
  input  logic              t_zero_i,
  input  logic              t_link_i,
  input  logic              invert_i,
  output logic              skip_o
);
  logic hit;

  always_comb begin
    hit    = (t_neg_i & ac_i[WORD_W-1]) | (t_zero_i & (ac_i == '0)) | (t_link_i & link_i);
    skip_o = hit ^ invert_i;
  end

  // R8: inverted form with no test selected always skips
  always_comb begin
    if (invert_i && !t_neg_i && !t_zero_i && !t_link_i)
      p_skip_always_r8: assert (skip_o);
  end
endmodule

// File: rtl/acc12_mqu.sv
`timescale 1ns/1ps
module acc12_mqu import acc12_pkg::*; (
  input  logic [WORD_W-1:0] ac_i,
  input  logic [WORD_W-1:0] mq_i,
  input  logic              clr_i,
  input  logic              or_mq_i,
  input  logic              ld_mq_i,
  output logic [WORD_W-1:0] ac_o,
  output logic [WORD_W-1:0] mq_o
);
  logic [WORD_W-1:0] a1;

  always_comb begin
    a1   = clr_i ? '0 : ac_i;
    mq_o = ld_mq_i ? a1 : mq_i;
    ac_o = (ld_mq_i ? '0 : a1) | (or_mq_i ? mq_i : '0);
  end

  // R10: exchange without clear swaps the two registers
  always_comb begin
    if (or_mq_i && ld_mq_i && !clr_i)
      p_swap_r10: assert (ac_o == mq_i && mq_o == ac_i);
  end
endmodule

// File: rtl/acc12_core.sv
`timescale 1ns/1ps
module acc12_core import acc12_pkg::*; #(
  parameter logic [WORD_W-1:0] START_PC  = 12'o0200,
  parameter logic [WORD_W-1:0] SAVE_ADDR = 12'o0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              halted_o,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] ac_o,
  output logic              link_o
);
  localparam logic [WORD_W-1:0] ONE  = {{(WORD_W-1){1'b0}}, 1'b1};
  localparam logic [WORD_W-1:0] TWO  = ONE + ONE;
  localparam logic [8:0]        IOT_ON  = 9'o001;
  localparam logic [8:0]        IOT_OFF = 9'o002;

  state_e            state;
  logic [WORD_W-1:0] pc, ac, mq, ir, ea;
  logic              link, ien, ion_hold;

  // decode view: the fetched word during DECODE, the held word afterwards
  logic [WORD_W-1:0] instr;
  opcode_e           op;
  logic [WORD_W-1:0] ea_dir;
  logic              is_memref;
  assign instr     = (state == ST_DECODE) ? mem_rdata : ir;
  assign op        = opcode_e'(instr[WORD_W-1:WORD_W-OP_W]);
  assign ea_dir    = eff_addr(pc, instr[OFFS_W], instr[OFFS_W-1:0]);
  assign is_memref = (op != OP_IOT) && (op != OP_OPR);

  // operate-group units
  logic [WORD_W-1:0] g1_ac, mq_ac, mq_mq;
  logic              g1_link, skip_w;

  acc12_opr1 u_opr1 (
    .ac_i(ac), .link_i(link), .ctl_i(instr[7:0]),
    .ac_o(g1_ac), .link_o(g1_link)
  );

  acc12_skip u_skip (
    .ac_i(ac), .link_i(link),
    .t_neg_i(instr[6]), .t_zero_i(instr[5]), .t_link_i(instr[4]),
    .invert_i(instr[3]), .skip_o(skip_w)
  );

  acc12_mqu u_mqu (
    .ac_i(ac), .mq_i(mq),
    .clr_i(instr[7]), .or_mq_i(instr[6]), .ld_mq_i(instr[4]),
    .ac_o(mq_ac), .mq_o(mq_mq)
  );

  // named events
  logic              take_int, ion_evt, iof_evt, skip_evt, grp2, grp3, isz_skip;
  logic [WORD_W-1:0] inc_w;
  logic [WORD_W:0]   tad_w;
  assign inc_w    = mem_rdata + ONE;
  assign tad_w    = add_link(link, ac, mem_rdata);
  assign take_int = (state == ST_FETCH) && irq && ien && !ion_hold;
  assign ion_evt  = (state == ST_DECODE) && (op == OP_IOT) && (instr[8:0] == IOT_ON);
  assign iof_evt  = (state == ST_DECODE) && (op == OP_IOT) && (instr[8:0] == IOT_OFF);
  assign grp2     = (op == OP_OPR) && instr[8] && !instr[0];
  assign grp3     = (op == OP_OPR) && instr[8] && instr[0];
  assign skip_evt = (state == ST_DECODE) && grp2 && skip_w;
  assign isz_skip = (state == ST_RDOP) && (op == OP_ISZ) && (inc_w == '0);

  // memory port
  always_comb begin
    mem_addr  = pc;
    mem_wdata = '0;
    mem_we    = 1'b0;
    unique case (state)
      ST_FETCH: if (take_int) begin
        mem_addr  = SAVE_ADDR;
        mem_wdata = pc;
        mem_we    = 1'b1;
      end
      ST_DECODE: mem_addr = ea_dir;
      ST_INDIR:  mem_addr = ea;
      ST_MEMOP: begin
        mem_addr = ea;
        if (op == OP_DCA) begin
          mem_wdata = ac;
          mem_we    = 1'b1;
        end else if (op == OP_JMS) begin
          mem_wdata = pc;
          mem_we    = 1'b1;
        end
      end
      ST_RDOP: begin
        mem_addr = ea;
        if (op == OP_ISZ) begin
          mem_wdata = inc_w;
          mem_we    = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_FETCH;
      pc       <= START_PC;
      ac       <= '0;
      mq       <= '0;
      link     <= 1'b0;
      ir       <= '0;
      ea       <= '0;
      ien      <= 1'b0;
      ion_hold <= 1'b0;
    end else begin
      unique case (state)
        ST_FETCH: begin
          if (take_int) begin
            pc  <= SAVE_ADDR + ONE;
            ien <= 1'b0;
          end else begin
            ion_hold <= 1'b0;
            state    <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          ir    <= mem_rdata;
          pc    <= pc + ONE;
          state <= ST_FETCH;
          if (is_memref) begin
            ea    <= ea_dir;
            state <= instr[8] ? ST_INDIR : ST_MEMOP;
          end else if (op == OP_IOT) begin
            if (ion_evt) begin
              ien      <= 1'b1;
              ion_hold <= 1'b1;
            end
            if (iof_evt) ien <= 1'b0;
          end else if (!instr[8]) begin
            ac   <= g1_ac;
            link <= g1_link;
          end else if (grp2) begin
            if (skip_w)   pc <= pc + TWO;
            if (instr[7]) ac <= '0;
            if (instr[1]) state <= ST_HALT;
          end else if (grp3) begin
            ac <= mq_ac;
            mq <= mq_mq;
          end
        end
        ST_INDIR: begin
          ea    <= mem_rdata;
          state <= ST_MEMOP;
        end
        ST_MEMOP: begin
          state <= ST_FETCH;
          case (op)
            OP_AND, OP_TAD, OP_ISZ: state <= ST_RDOP;
            OP_DCA: ac <= '0;
            OP_JMS: pc <= ea + ONE;
            OP_JMP: pc <= ea;
            default: ;
          endcase
        end
        ST_RDOP: begin
          state <= ST_FETCH;
          case (op)
            OP_AND: ac <= ac & mem_rdata;
            OP_TAD: {link, ac} <= tad_w;
            OP_ISZ: if (inc_w == '0) pc <= pc + ONE;
            default: ;
          endcase
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  assign halted_o = (state == ST_HALT);
  assign pc_o     = pc;
  assign ac_o     = ac;
  assign link_o   = link;

  // R8: a taken skip leaves PC two past the skip instruction
  p_skip_adv_r8: assert property (@(posedge clk) disable iff (rst)
    skip_evt |=> pc == $past(pc) + TWO);

  // R4: a zero result of ISZ steps past the following word
  p_isz_skip_r4: assert property (@(posedge clk) disable iff (rst)
    isz_skip |=> pc == $past(pc) + ONE);

  // R5: a store leaves AC cleared
  p_dca_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MEMOP && op == OP_DCA) |=> ac == '0);

  // R9: halt is sticky, PC frozen, no writes
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> halted_o && $stable(pc) && !mem_we);

  // R11: an accepted interrupt vectors after the save word and disables itself
  p_int_vector_r11: assert property (@(posedge clk) disable iff (rst)
    take_int |=> pc == SAVE_ADDR + ONE && !ien);

  // R12: enabling does not admit an interrupt at the very next boundary
  p_ion_delay_r12: assert property (@(posedge clk) disable iff (rst)
    ion_evt |=> !take_int);
endmodule

// File: tb/sim_acc12_core.sv
`timescale 1ns/1ps
module sim_acc12_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic [11:0] mem_rdata;
  logic [11:0] mem_addr, mem_wdata;
  logic        mem_we, halted_o, link_o;
  logic [11:0] pc_o, ac_o;
  logic [11:0] mem [4096];
  int          n_tests = 0;
  int          n_fail  = 0;

  always #2.5 clk = ~clk;

  acc12_core u0 (
    .clk(clk), .rst(rst), .irq(irq), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .halted_o(halted_o), .pc_o(pc_o), .ac_o(ac_o), .link_o(link_o)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  typedef struct packed {
    logic [11:0] op;
    logic [11:0] ac;
    logic [11:0] mq;
    logic        l;
    logic [11:0] eac;
    logic        el;
    logic [11:0] epc;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{12'o7040, 12'o1234, 12'o0000, 1'b0, 12'o6543, 1'b0, 12'o0207},
    '{12'o7001, 12'o7777, 12'o0000, 1'b0, 12'o0000, 1'b1, 12'o0207},
    '{12'o7004, 12'o4001, 12'o0000, 1'b0, 12'o0002, 1'b1, 12'o0207},
    '{12'o7010, 12'o0001, 12'o0000, 1'b1, 12'o4000, 1'b1, 12'o0207},
    '{12'o7360, 12'o1234, 12'o0000, 1'b1, 12'o7777, 1'b1, 12'o0207},
    '{12'o7041, 12'o7777, 12'o0000, 1'b0, 12'o0001, 1'b0, 12'o0207},
    '{12'o7012, 12'o0003, 12'o0000, 1'b0, 12'o4000, 1'b1, 12'o0207},
    '{12'o7500, 12'o4000, 12'o0000, 1'b0, 12'o4000, 1'b0, 12'o0210},
    '{12'o7440, 12'o0001, 12'o0000, 1'b0, 12'o0001, 1'b0, 12'o0207},
    '{12'o7420, 12'o0000, 12'o0000, 1'b1, 12'o0000, 1'b1, 12'o0210},
    '{12'o7510, 12'o4000, 12'o0000, 1'b0, 12'o4000, 1'b0, 12'o0207},
    '{12'o7410, 12'o0077, 12'o0000, 1'b0, 12'o0077, 1'b0, 12'o0210},
    '{12'o7650, 12'o0123, 12'o0000, 1'b0, 12'o0000, 1'b0, 12'o0210},
    '{12'o7501, 12'o0070, 12'o1400, 1'b0, 12'o1470, 1'b0, 12'o0207},
    '{12'o7521, 12'o0055, 12'o3300, 1'b0, 12'o3300, 1'b0, 12'o0207},
    '{12'o7701, 12'o1111, 12'o0022, 1'b0, 12'o0022, 1'b0, 12'o0207}
  };

  task automatic chk(input string req, input string what,
                     input logic [11:0] act, input logic [11:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %o expected %o", req, what, act, exp);
    end
  endtask

  // fill memory with halts, then hold reset
  task automatic wipe();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 4096; i++) mem[i] = 12'o7402;
  endtask

  task automatic run();
    int cyc;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!halted_o && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    n_tests++;
    if (!halted_o) begin
      n_fail++;
      $display("FAIL R9 program did not halt: got %0d expected 1", halted_o);
    end
  endtask

  initial begin
    #(5ns * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    wipe();
    repeat (3) @(negedge clk);
    chk("R1", "pc in reset", pc_o, 12'o0200);
    chk("R1", "ac in reset", ac_o, 12'o0000);
    chk("R1", "link/halt/we in reset", {9'd0, link_o, halted_o, mem_we}, 12'o0000);

    // table of operate-group vectors: R7 / R8 / R10
    for (int v = 0; v < 16; v++) begin
      string rq;
      rq = !VECS[v].op[8] ? "R7" : (VECS[v].op[0] ? "R10" : "R8");
      wipe();
      mem[12'o100] = VECS[v].ac;
      mem[12'o101] = VECS[v].mq;
      mem[12'o200] = 12'o7300;
      mem[12'o201] = 12'o1101;
      mem[12'o202] = 12'o7421;
      mem[12'o203] = 12'o1100;
      mem[12'o204] = VECS[v].l ? 12'o7020 : 12'o7000;
      mem[12'o205] = VECS[v].op;
      run();
      chk(rq, $sformatf("vec %0d ac", v), ac_o, VECS[v].eac);
      chk(rq, $sformatf("vec %0d link", v), {11'd0, link_o}, {11'd0, VECS[v].el});
      chk(rq, $sformatf("vec %0d pc", v), pc_o, VECS[v].epc);
    end

    // R4: ISZ wrap to zero skips
    wipe();
    mem[12'o100] = 12'o7777;
    mem[12'o200] = 12'o2100;
    run();
    chk("R4", "isz wrap word", mem[12'o100], 12'o0000);
    chk("R4", "isz wrap pc", pc_o, 12'o0203);
    // R4: no wrap, no skip
    wipe();
    mem[12'o100] = 12'o0005;
    mem[12'o200] = 12'o2100;
    run();
    chk("R4", "isz word", mem[12'o100], 12'o0006);
    chk("R4", "isz pc", pc_o, 12'o0202);

    // R2 R3 R5: indirect AND via page zero, DCA to current page
    wipe();
    mem[12'o100] = 12'o7070;
    mem[12'o101] = 12'o0300;
    mem[12'o300] = 12'o1717;
    mem[12'o200] = 12'o7300;
    mem[12'o201] = 12'o1100;
    mem[12'o202] = 12'o0501;
    mem[12'o203] = 12'o3250;
    run();
    chk("R2", "current page store", mem[12'o250], 12'o1010);
    chk("R2", "page zero word kept", mem[12'o050], 12'o7402);
    chk("R5", "ac after store", ac_o, 12'o0000);

    // R3: TAD carry complements link
    wipe();
    mem[12'o100] = 12'o7777;
    mem[12'o101] = 12'o0002;
    mem[12'o200] = 12'o7300;
    mem[12'o201] = 12'o1100;
    mem[12'o202] = 12'o1101;
    run();
    chk("R3", "tad sum", ac_o, 12'o0001);
    chk("R3", "tad link", {11'd0, link_o}, 12'o0001);

    // R6: call and return through saved word
    wipe();
    mem[12'o100] = 12'o0042;
    mem[12'o200] = 12'o4240;
    mem[12'o241] = 12'o1100;
    mem[12'o242] = 12'o5640;
    run();
    chk("R6", "saved return", mem[12'o240], 12'o0201);
    chk("R6", "returned pc", pc_o, 12'o0202);
    chk("R6", "body ran", ac_o, 12'o0042);

    // R9: halt is sticky
    repeat (8) @(negedge clk);
    chk("R9", "pc frozen", pc_o, 12'o0202);
    chk("R9", "still halted, no write", {10'd0, halted_o, mem_we}, 12'o0002);

    // R11 R12: interrupt after the instruction following ION
    wipe();
    irq = 1'b1;
    mem[12'o000] = 12'o5555;
    mem[12'o001] = 12'o3050;
    mem[12'o100] = 12'o0005;
    mem[12'o200] = 12'o6001;
    mem[12'o201] = 12'o1100;
    run();
    chk("R11", "saved pc", mem[12'o000], 12'o0202);
    chk("R11", "vector path pc", pc_o, 12'o0003);
    chk("R12", "instr after ION completed", mem[12'o050], 12'o0005);

    // R12: IOF cancels, other IOT no effect
    wipe();
    mem[12'o000] = 12'o5555;
    mem[12'o100] = 12'o0321;
    mem[12'o200] = 12'o6001;
    mem[12'o201] = 12'o6002;
    mem[12'o202] = 12'o1100;
    mem[12'o203] = 12'o6035;
    run();
    chk("R12", "no interrupt after IOF", mem[12'o000], 12'o5555);
    chk("R12", "pc", pc_o, 12'o0205);
    chk("R12", "other IOT keeps ac", ac_o, 12'o0321);
    irq = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule